// File: doc/BRIEF.md
# Bulk Reply Line Sequencer

This block sits at the home node of a shared-memory system. It runs after the directory has granted a requester an aligned block of 2^k cache lines. It turns that one grant into a series of single-line reply messages. The line the requester asked for goes out first, as the primary data message for a read or a write. The other lines of the aligned block follow, one per message, each tagged as a bulk-remainder message. Every message carries the base line and the size of the granted range, so the receiver can place each line without searching.

A grant gives the page, the requested line offset inside the page, the size exponent k and a read/write flag. The block takes a new grant only while it is idle. For each line it reads the home memory through a port with one cycle of read latency. It then presents the message on a valid/ready output and holds it there until the consumer takes it.

Top module: `bulk_reply_seq`

## Requirements
- R1: After reset, `msg_valid` and `mem_rd_en` are 0 and `grant_ready` is 1.
- R2: A grant is taken only on a cycle where `grant_valid` and `grant_ready` are both 1. `grant_ready` stays 0 from that cycle until the final message of the grant has been accepted. A `grant_valid` asserted in between has no effect on the message stream.
- R3: The first message of a grant carries `msg_line` equal to the requested line. Its `msg_type` is 0 for a read grant and 1 for a write grant.
- R4: Every later message is a remainder message, with `msg_type` 2 for a read and 3 for a write. Remainder messages cover every other line of the block exactly once, in ascending offset order from the block base, and they skip the requested line.
- R5: A grant produces exactly 2^k messages. With k = 0 it produces only the primary message, and that message has `msg_last` set.
- R6: Every message carries `msg_base`, which is the requested line with its low k bits cleared, and `msg_log2`, which is k.
- R7: `msg_last` is 1 on the final message of a grant and 0 on every other message.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, the message and all of its fields stay unchanged on the next cycle.
- R9: `msg_data` equals the memory word at address {page, line} (page in the high bits) for the line that the message names.
- R10: A `grant_log2` larger than log2 of the lines per page is treated as a whole-page grant, and `msg_log2` reports that clamped value.
- R11: `msg_page` equals the page of the grant on every message of that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_valid | input | 1 | Directory grant present |
| grant_ready | output | 1 | Sequencer idle, grant can be taken |
| grant_page | input | PAGE_W | Page of the grant |
| grant_line | input | OFF_W | Requested line offset in the page |
| grant_log2 | input | K_W | Block size exponent k |
| grant_write | input | 1 | 1 for a write grant, 0 for a read |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PAGE_W+OFF_W | Line address {page, line} |
| mem_rd_data | input | DATA_W | Read data, one cycle after the strobe |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Consumer takes the message |
| msg_type | output | 2 | 0 read primary, 1 write primary, 2 read remainder, 3 write remainder |
| msg_page | output | PAGE_W | Page of the message |
| msg_line | output | OFF_W | Line offset carried by the message |
| msg_base | output | OFF_W | First line of the granted range |
| msg_log2 | output | K_W | Size exponent of the granted range |
| msg_last | output | 1 | Final message of the grant |
| msg_data | output | DATA_W | Line data |

## Verification
If the line walker's counter is corrupted, a line appears twice or goes missing. It may also break the ascending order, and that shows at the ports on the next message or the one after. If the last-line decode is off, the message count is wrong or `grant_ready` comes back at the wrong time, which the bench sees within one message of the end of the grant. A stale latched grant field shows at once as a wrong base, size, page or data word on the first message. An output register that is not held shows as a change during a stall, within one cycle of the stall.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        MSG_RD_PRI  = 2'd0,
        MSG_WR_PRI  = 2'd1,
        MSG_RD_REST = 2'd2,
        MSG_WR_REST = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_CAPT,
        SQ_SEND
    } seq_state_e;

    // first line of the aligned 2^k block that holds req
    function automatic int unsigned blk_base(int unsigned req, int unsigned k);
        return (req >> k) << k;
    endfunction

    // line offset of the n-th message: requested line first, then the rest ascending
    function automatic int unsigned nth_off(int unsigned req, int unsigned k, int unsigned n);
        int unsigned base;
        int unsigned rel;
        base = blk_base(req, k);
        rel  = req - base;
        if (n == 0)
            return req;
        else if ((n - 1) < rel)
            return base + n - 1;
        else
            return base + n;
    endfunction

    function automatic msg_kind_e kind_of(logic wr, logic first);
        if (first)
            return wr ? MSG_WR_PRI : MSG_RD_PRI;
        else
            return wr ? MSG_WR_REST : MSG_RD_REST;
    endfunction

endpackage

// File: rtl/brs_walker.sv
module brs_walker
    import brs_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int K_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [OFF_W-1:0] req_off,
    input  logic [K_W-1:0]   k,
    output logic [OFF_W-1:0] cur_off,
    output logic             is_first,
    output logic             is_last
);
    localparam int CNT_W = OFF_W + 1;

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] final_idx;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (load)
            idx <= '0;
        else if (step)
            idx <= idx + CNT_W'(1);
    end

    assign final_idx = (CNT_W'(1) << k) - CNT_W'(1);
    assign is_first  = (idx == '0);
    assign is_last   = (idx == final_idx);
    assign cur_off   = OFF_W'(nth_off(32'(req_off), 32'(k), 32'(idx)));

endmodule

// File: rtl/brs_stage.sv
module brs_stage
    import brs_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 4,
    parameter int K_W    = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  msg_kind_e         in_kind,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [OFF_W-1:0]  in_line,
    input  logic [OFF_W-1:0]  in_base,
    input  logic [K_W-1:0]    in_log2,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [PAGE_W-1:0] out_page,
    output logic [OFF_W-1:0]  out_line,
    output logic [OFF_W-1:0]  out_base,
    output logic [K_W-1:0]    out_log2,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_page  <= '0;
            out_line  <= '0;
            out_base  <= '0;
            out_log2  <= '0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (capture) begin
            out_valid <= 1'b1;
            out_kind  <= in_kind;
            out_page  <= in_page;
            out_line  <= in_line;
            out_base  <= in_base;
            out_log2  <= in_log2;
            out_last  <= in_last;
            out_data  <= in_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bulk_reply_seq.sv
module bulk_reply_seq
    import brs_pkg::*;
#(
    parameter int PAGE_W         = 4,
    parameter int LINES_PER_PAGE = 16,
    parameter int DATA_W         = 32,
    localparam int OFF_W         = $clog2(LINES_PER_PAGE),
    localparam int K_W           = $clog2(OFF_W + 1),
    localparam int ADDR_W        = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_valid,
    output logic              grant_ready,
    input  logic [PAGE_W-1:0] grant_page,
    input  logic [OFF_W-1:0]  grant_line,
    input  logic [K_W-1:0]    grant_log2,
    input  logic              grant_write,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_type,
    output logic [PAGE_W-1:0] msg_page,
    output logic [OFF_W-1:0]  msg_line,
    output logic [OFF_W-1:0]  msg_base,
    output logic [K_W-1:0]    msg_log2,
    output logic              msg_last,
    output logic [DATA_W-1:0] msg_data
);
    seq_state_e        state, state_nx;
    logic [PAGE_W-1:0] g_page;
    logic [OFF_W-1:0]  g_req;
    logic [K_W-1:0]    g_k;
    logic              g_wr;
    logic [K_W-1:0]    k_in;
    logic              take;
    logic              step;
    logic              capture;
    logic [OFF_W-1:0]  cur_off;
    logic              is_first;
    logic              is_last;
    logic [OFF_W-1:0]  base_off;

    assign k_in = (grant_log2 > K_W'(OFF_W)) ? K_W'(OFF_W) : grant_log2;

    assign grant_ready = (state == SQ_IDLE);
    assign take        = grant_valid && grant_ready;
    assign mem_rd_en   = (state == SQ_READ);
    assign mem_rd_addr = {g_page, cur_off};
    assign capture     = (state == SQ_CAPT);
    assign step        = (state == SQ_SEND) && msg_valid && msg_ready && !is_last;
    assign base_off    = OFF_W'(blk_base(32'(g_req), 32'(g_k)));

    always_comb begin
        state_nx = state;
        case (state)
            SQ_IDLE: if (grant_valid) state_nx = SQ_READ;
            SQ_READ: state_nx = SQ_CAPT;
            SQ_CAPT: state_nx = SQ_SEND;
            SQ_SEND: if (msg_valid && msg_ready) state_nx = is_last ? SQ_IDLE : SQ_READ;
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            g_page <= '0;
            g_req  <= '0;
            g_k    <= '0;
            g_wr   <= 1'b0;
        end else begin
            state <= state_nx;
            if (take) begin
                g_page <= grant_page;
                g_req  <= grant_line;
                g_k    <= k_in;
                g_wr   <= grant_write;
            end
        end
    end

    brs_walker #(
        .OFF_W (OFF_W),
        .K_W   (K_W)
    ) i_walker (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .step     (step),
        .req_off  (g_req),
        .k        (g_k),
        .cur_off  (cur_off),
        .is_first (is_first),
        .is_last  (is_last)
    );

    brs_stage #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .K_W    (K_W),
        .DATA_W (DATA_W)
    ) i_stage (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .in_kind   (kind_of(g_wr, is_first)),
        .in_page   (g_page),
        .in_line   (cur_off),
        .in_base   (base_off),
        .in_log2   (g_k),
        .in_last   (is_last),
        .in_data   (mem_rd_data),
        .out_ready (msg_ready),
        .out_valid (msg_valid),
        .out_kind  (msg_type),
        .out_page  (msg_page),
        .out_line  (msg_line),
        .out_base  (msg_base),
        .out_log2  (msg_log2),
        .out_last  (msg_last),
        .out_data  (msg_data)
    );

endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 4,
    parameter int K_W    = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              grant_ready,
    input logic              mem_rd_en,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_type,
    input logic [PAGE_W-1:0] msg_page,
    input logic [OFF_W-1:0]  msg_line,
    input logic [OFF_W-1:0]  msg_base,
    input logic [K_W-1:0]    msg_log2,
    input logic              msg_last,
    input logic [DATA_W-1:0] msg_data
);
    logic [OFF_W-1:0] prev_line;
    logic             prev_rest;
    logic             is_rest;

    assign is_rest = msg_type[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_line <= '0;
            prev_rest <= 1'b0;
        end else if (msg_valid && msg_ready) begin
            prev_line <= msg_line;
            prev_rest <= is_rest && !msg_last;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> (!msg_valid && grant_ready && !mem_rd_en));

    // R2
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid || mem_rd_en) |-> !grant_ready);

    // R8
    hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_line)
            && $stable(msg_type) && $stable(msg_last) && $stable(msg_page));

    // R5
    single_line_last_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && (msg_log2 == '0) |-> msg_last && !is_rest);

    // R6
    line_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (((msg_line ^ msg_base) >> msg_log2) == '0)
            && ((msg_base & ((OFF_W'(1) << msg_log2) - OFF_W'(1))) == '0));

    // R4
    rest_ascending_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && is_rest && prev_rest |-> msg_line > prev_line);

    // R7
    last_frees_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready && msg_last |=> grant_ready);

endmodule

bind bulk_reply_seq brs_chk #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .K_W    (K_W),
    .DATA_W (DATA_W)
) i_brs_chk (
    .clk         (clk),
    .rst         (rst),
    .grant_ready (grant_ready),
    .mem_rd_en   (mem_rd_en),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_type    (msg_type),
    .msg_page    (msg_page),
    .msg_line    (msg_line),
    .msg_base    (msg_base),
    .msg_log2    (msg_log2),
    .msg_last    (msg_last),
    .msg_data    (msg_data)
);

// File: tb/test_bulk_reply_seq.sv
module test_bulk_reply_seq;
    localparam int PAGE_W = 4;
    localparam int LPP    = 16;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 4;
    localparam int K_W    = 3;
    localparam int ADDR_W = PAGE_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              grant_valid = 1'b0;
    logic              grant_ready;
    logic [PAGE_W-1:0] grant_page = '0;
    logic [OFF_W-1:0]  grant_line = '0;
    logic [K_W-1:0]    grant_log2 = '0;
    logic              grant_write = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic [1:0]        msg_type;
    logic [PAGE_W-1:0] msg_page;
    logic [OFF_W-1:0]  msg_line;
    logic [OFF_W-1:0]  msg_base;
    logic [K_W-1:0]    msg_log2;
    logic              msg_last;
    logic [DATA_W-1:0] msg_data;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
        return 32'hC3A5_0000 ^ (32'(a) * 32'h0001_0101);
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= memval(mem_rd_addr);
    end

    bulk_reply_seq #(
        .PAGE_W         (PAGE_W),
        .LINES_PER_PAGE (LPP),
        .DATA_W         (DATA_W)
    ) i_bulk_reply_seq (
        .clk         (clk),
        .rst         (rst),
        .grant_valid (grant_valid),
        .grant_ready (grant_ready),
        .grant_page  (grant_page),
        .grant_line  (grant_line),
        .grant_log2  (grant_log2),
        .grant_write (grant_write),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .msg_valid   (msg_valid),
        .msg_ready   (msg_ready),
        .msg_type    (msg_type),
        .msg_page    (msg_page),
        .msg_line    (msg_line),
        .msg_base    (msg_base),
        .msg_log2    (msg_log2),
        .msg_last    (msg_last),
        .msg_data    (msg_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_grant(input int page, input int req, input int k,
                             input bit wr, input bit stall, input bit junk);
        int keff;
        int base;
        int total;
        int rel;
        int eoff;
        logic [1:0] etype;
        logic [DATA_W-1:0] hold_data;
        logic [OFF_W-1:0]  hold_line;
        keff  = (k > OFF_W) ? OFF_W : k;
        base  = (req >> keff) << keff;
        total = 1 << keff;
        rel   = req - base;
        @(negedge clk);
        chk(grant_ready == 1'b1, "R2", "ready before grant", grant_ready, 1);
        grant_valid = 1'b1;
        grant_page  = PAGE_W'(page);
        grant_line  = OFF_W'(req);
        grant_log2  = K_W'(k);
        grant_write = wr;
        @(negedge clk);
        if (junk) begin
            grant_page  = PAGE_W'(page + 5);
            grant_line  = OFF_W'(req + 3);
            grant_log2  = '0;
            grant_write = ~wr;
        end else begin
            grant_valid = 1'b0;
        end
        for (int n = 0; n < total; n++) begin
            while (!msg_valid) @(negedge clk);
            if (n == 0) eoff = req;
            else if (n - 1 < rel) eoff = base + n - 1;
            else eoff = base + n;
            etype = (n == 0) ? {1'b0, wr} : {1'b1, wr};
            chk(grant_ready == 1'b0, "R2", "ready while busy", grant_ready, 0);
            if (n == 0) begin
                chk(msg_type == etype, "R3", "primary type", msg_type, etype);
                chk(msg_line == OFF_W'(eoff), "R3", "primary line", msg_line, eoff);
            end else begin
                chk(msg_type == etype, "R4", "rest type", msg_type, etype);
                chk(msg_line == OFF_W'(eoff), "R4", "rest line", msg_line, eoff);
            end
            chk(msg_base == OFF_W'(base), (k > OFF_W) ? "R10" : "R6", "base", msg_base, base);
            chk(msg_log2 == K_W'(keff), (k > OFF_W) ? "R10" : "R6", "log2", msg_log2, keff);
            chk(msg_page == PAGE_W'(page), "R11", "page", msg_page, page);
            chk(msg_data == memval({PAGE_W'(page), OFF_W'(eoff)}), "R9", "data",
                msg_data, memval({PAGE_W'(page), OFF_W'(eoff)}));
            chk(msg_last == (n == total - 1), (keff == 0) ? "R5" : "R7", "last",
                msg_last, (n == total - 1));
            if (stall) begin
                hold_data = msg_data;
                hold_line = msg_line;
                @(negedge clk);
                @(negedge clk);
                chk(msg_valid && msg_data == hold_data && msg_line == hold_line,
                    "R8", "held under stall", msg_line, hold_line);
            end
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
        grant_valid = 1'b0;
        @(negedge clk);
        chk(!msg_valid && grant_ready, "R5", "no extra message", msg_valid, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!msg_valid, "R1", "reset msg_valid", msg_valid, 0);
        chk(grant_ready, "R1", "reset grant_ready", grant_ready, 1);
        chk(!mem_rd_en, "R1", "reset mem_rd_en", mem_rd_en, 0);
        for (int wr = 0; wr < 2; wr++)
            for (int k = 0; k <= OFF_W; k++)
                for (int req = 0; req < LPP; req++)
                    run_grant((req + k + wr) % 16, req, k, wr[0],
                              ((req + k) % 5) == 0, (req % 7) == 3);
        for (int k = OFF_W + 1; k < 8; k++) begin
            run_grant(9, 6, k, 1'b0, 1'b0, 1'b0);
            run_grant(2, 11, k, 1'b1, 1'b1, 1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule